// File: doc/BRIEF.md
# Banked Block-Copy DMA Engine

This block is a byte-wide memory-to-memory copy engine that sits beside an 8-bit processor with a 16-bit address bus. Software loads a source pointer, a destination pointer, a source bank and a length through a small set of byte-wide registers. A write to the length's low byte launches the copy. The engine then owns the bus and raises a halt request to the processor until the last byte has landed. Each byte costs one read cycle followed by one write cycle.

Reads whose source address has its top bit set are steered into a larger data memory through a window. The window's upper address bits come from the bank register. When the source pointer runs off the top of the address space it falls back to the start of the window and the bank moves on by one, so a long copy can stream across bank boundaries. A mode bit freezes the destination, which lets the engine pour a whole block into a single port address. The pointers and the bank stay readable and keep their advanced values, so a second block can continue where the first stopped.

Top module: `dma_bank_copy`

## Requirements
- R1: After reset every register reads 0x00, `busy` is low and neither `m_rd` nor `m_wr` is asserted.
- R2: Register offsets: 0x28/0x29 source pointer low/high, 0x2A/0x2B destination pointer low/high, 0x36 bank bits 7:0, 0x37 bank bits 10:8 in data bits 2:0. A read of 0x37 returns zero in bits 7:3. The length registers 0x2C and 0x2D read back as 0x00.
- R3: While idle, a write of D to 0x2C starts a copy of length L = {0x2D bits 3:0, D}. The copy moves L+1 bytes. `busy` rises in the cycle after the write and stays high for exactly 2*(L+1) cycles.
- R4: Each byte uses one cycle with `m_rd` high and `m_addr` equal to the source pointer. The next cycle has `m_wr` high, `m_addr` equal to the destination pointer, and `m_wdata` equal to the byte returned on `m_rdata` during that read.
- R5: During a read with source bit 15 set, `m_ext_sel` is high and `m_ext_addr` equals {bank, source[14:0]}. When source bit 15 is clear, `m_ext_sel` is low.
- R6: After each byte the source pointer increments. From 0xFFFF it reloads to 0x8000, and the bank then increments modulo 2048.
- R7: With 0x2D bit 4 clear, the destination pointer increments after each byte. With it set, every byte of the copy is written to the same destination address and the pointer is left unchanged.
- R8: The destination pointer wraps from 0xFFFF to 0x0000 with no effect on the bank.
- R9: After a copy of N bytes, the registers read back the advanced source pointer, destination pointer and bank.
- R10: Register writes made while `busy` is high have no effect. This includes a second write to 0x2C, which neither restarts nor extends the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| busy | output | 1 | Copy in progress; processor halt request |
| m_rd | output | 1 | Bus read cycle |
| m_wr | output | 1 | Bus write cycle |
| m_addr | output | 16 | Bus address (source on reads, destination on writes) |
| m_ext_sel | output | 1 | Current read targets the banked data memory |
| m_ext_addr | output | 26 | Banked data-memory read address |
| m_wdata | output | 8 | Bus write data |
| m_rdata | input | 8 | Bus read data |

## Verification
The hardest case to reach is the source carry into the bank, because it happens only when a copy crosses source address 0xFFFF. The stimulus starts the bank at its top value and the source two bytes below the carry, then runs a four-byte copy. This one copy shows the window reload to 0x8000, the bank rolling over to zero, and the change in the extended read address in the middle of the copy. The destination wrap and the writes ignored while busy are reached the same way: the pointers are placed next to the boundary, and register writes are issued only after the halt has begun.

// File: rtl/dma_bank_copy_pkg.sv
package dma_bank_copy_pkg;

  // register offsets decoded by the processor-side address map
  localparam logic [7:0] OFS_SRC_LO  = 8'h28;
  localparam logic [7:0] OFS_SRC_HI  = 8'h29;
  localparam logic [7:0] OFS_DST_LO  = 8'h2A;
  localparam logic [7:0] OFS_DST_HI  = 8'h2B;
  localparam logic [7:0] OFS_LEN_LO  = 8'h2C;
  localparam logic [7:0] OFS_LEN_HI  = 8'h2D;
  localparam logic [7:0] OFS_BANK_LO = 8'h36;
  localparam logic [7:0] OFS_BANK_HI = 8'h37;

  // bit of the length-high register that freezes the destination
  localparam int unsigned HOLD_BIT = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_bank_copy_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned BANK_W = 11,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              busy,
  input  logic              step,
  output logic              start,
  output logic [CNT_W-1:0]  load_len,
  output logic [AW-1:0]     src,
  output logic [AW-1:0]     dst,
  output logic [BANK_W-1:0] bank
);

  localparam int unsigned LEN_HI_W = CNT_W - 8;
  localparam int unsigned BANK_HW  = BANK_W - 8;
  localparam logic [AW-1:0] SRC_ALL1   = {AW{1'b1}};
  localparam logic [AW-1:0] WIN_BASE   = {1'b1, {(AW-1){1'b0}}};

  logic [AW-1:0]       src_q, src_d;
  logic [AW-1:0]       dst_q, dst_d;
  logic [BANK_W-1:0]   bank_q, bank_d;
  logic [LEN_HI_W-1:0] len_hi_q, len_hi_d;
  logic                hold_q, hold_d;
  logic                wr_ok;

  assign wr_ok    = reg_we && !busy;
  assign start    = wr_ok && (reg_sel == OFS_LEN_LO);
  assign load_len = {len_hi_q, reg_wdata};

  // next-state logic: software writes when idle, pointer advance per byte
  always_comb begin
    src_d    = src_q;
    dst_d    = dst_q;
    bank_d   = bank_q;
    len_hi_d = len_hi_q;
    hold_d   = hold_q;
    if (wr_ok) begin
      case (reg_sel)
        OFS_SRC_LO:  src_d[7:0]      = reg_wdata;
        OFS_SRC_HI:  src_d[AW-1:8]   = reg_wdata;
        OFS_DST_LO:  dst_d[7:0]      = reg_wdata;
        OFS_DST_HI:  dst_d[AW-1:8]   = reg_wdata;
        OFS_BANK_LO: bank_d[7:0]     = reg_wdata;
        OFS_BANK_HI: bank_d[BANK_W-1:8] = reg_wdata[BANK_HW-1:0];
        OFS_LEN_HI: begin
          len_hi_d = reg_wdata[LEN_HI_W-1:0];
          hold_d   = reg_wdata[HOLD_BIT];
        end
        default: ;
      endcase
    end else if (step) begin
      if (src_q == SRC_ALL1) begin
        src_d  = WIN_BASE;
        bank_d = bank_q + 1'b1;
      end else begin
        src_d  = src_q + 1'b1;
      end
      if (!hold_q) begin
        dst_d = dst_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      bank_q   <= '0;
      len_hi_q <= '0;
      hold_q   <= 1'b0;
    end else begin
      src_q    <= src_d;
      dst_q    <= dst_d;
      bank_q   <= bank_d;
      len_hi_q <= len_hi_d;
      hold_q   <= hold_d;
    end
  end

  // read mux; the length registers are write-only
  always_comb begin
    case (reg_sel)
      OFS_SRC_LO:  reg_rdata = src_q[7:0];
      OFS_SRC_HI:  reg_rdata = src_q[AW-1:8];
      OFS_DST_LO:  reg_rdata = dst_q[7:0];
      OFS_DST_HI:  reg_rdata = dst_q[AW-1:8];
      OFS_BANK_LO: reg_rdata = bank_q[7:0];
      OFS_BANK_HI: reg_rdata = {{(8-BANK_HW){1'b0}}, bank_q[BANK_W-1:8]};
      default:     reg_rdata = 8'h00;
    endcase
  end

  assign src  = src_q;
  assign dst  = dst_q;
  assign bank = bank_q;

endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_bank_copy_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_len,
  output logic             rd_phase,
  output logic             wr_phase,
  output logic             step,
  output logic             busy
);

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             left_en;

  always_comb begin
    ph_d    = ph_q;
    left_d  = left_q;
    left_en = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d    = PH_READ;
          left_d  = load_len;
          left_en = 1'b1;
        end
      end
      PH_READ: begin
        ph_d = PH_WRITE;
      end
      PH_WRITE: begin
        // the copy ends once the remaining count would drop below zero
        if (left_q == '0) begin
          ph_d = PH_IDLE;
        end else begin
          ph_d    = PH_READ;
          left_d  = left_q - 1'b1;
          left_en = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  assign rd_phase = (ph_q == PH_READ);
  assign wr_phase = (ph_q == PH_WRITE);
  assign step     = wr_phase;
  assign busy     = (ph_q != PH_IDLE);

endmodule

// File: rtl/dma_bus_port.sv
module dma_bus_port #(
  parameter int unsigned AW     = 16,
  parameter int unsigned BANK_W = 11,
  parameter int unsigned DW     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_phase,
  input  logic                   wr_phase,
  input  logic [AW-1:0]          src,
  input  logic [AW-1:0]          dst,
  input  logic [BANK_W-1:0]      bank,
  input  logic [DW-1:0]          m_rdata,
  output logic                   m_rd,
  output logic                   m_wr,
  output logic [AW-1:0]          m_addr,
  output logic                   m_ext_sel,
  output logic [BANK_W+AW-2:0]   m_ext_addr,
  output logic [DW-1:0]          m_wdata
);

  logic [DW-1:0] hold_q;

  // byte captured at the end of the read cycle, driven in the write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (rd_phase) begin
      hold_q <= m_rdata;
    end
  end

  assign m_rd       = rd_phase;
  assign m_wr       = wr_phase;
  assign m_addr     = wr_phase ? dst : src;
  assign m_ext_sel  = rd_phase && src[AW-1];
  assign m_ext_addr = {bank, src[AW-2:0]};
  assign m_wdata    = hold_q;

endmodule

// File: rtl/dma_bank_copy.sv
module dma_bank_copy #(
  parameter int unsigned AW     = 16,
  parameter int unsigned BANK_W = 11,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [7:0]           reg_sel,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic                 busy,
  output logic                 m_rd,
  output logic                 m_wr,
  output logic [AW-1:0]        m_addr,
  output logic                 m_ext_sel,
  output logic [BANK_W+AW-2:0] m_ext_addr,
  output logic [DW-1:0]        m_wdata,
  input  logic [DW-1:0]        m_rdata
);

  logic             start;
  logic             step;
  logic             rd_phase;
  logic             wr_phase;
  logic [CNT_W-1:0] load_len;
  logic [AW-1:0]    src;
  logic [AW-1:0]    dst;
  logic [BANK_W-1:0] bank_q;

  dma_cfg_regs #(.AW(AW), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (busy),
    .step     (step),
    .start    (start),
    .load_len (load_len),
    .src      (src),
    .dst      (dst),
    .bank     (bank_q)
  );

  dma_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .load_len(load_len),
    .rd_phase(rd_phase),
    .wr_phase(wr_phase),
    .step    (step),
    .busy    (busy)
  );

  dma_bus_port #(.AW(AW), .BANK_W(BANK_W), .DW(DW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_phase  (rd_phase),
    .wr_phase  (wr_phase),
    .src       (src),
    .dst       (dst),
    .bank      (bank_q),
    .m_rdata   (m_rdata),
    .m_rd      (m_rd),
    .m_wr      (m_wr),
    .m_addr    (m_addr),
    .m_ext_sel (m_ext_sel),
    .m_ext_addr(m_ext_addr),
    .m_wdata   (m_wdata)
  );

endmodule

// File: rtl/dma_bank_copy_chk.sv
module dma_bank_copy_chk #(
  parameter int unsigned BANK_W = 11,
  parameter int unsigned DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [7:0]        reg_sel,
  input logic              busy,
  input logic              m_rd,
  input logic              m_wr,
  input logic [DW-1:0]     m_wdata,
  input logic [DW-1:0]     m_rdata,
  input logic [BANK_W-1:0] bank_q
);

  // R4: a read and a write never share a cycle
  a_r4_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_rd && m_wr));

  // R4: every read cycle is followed by its write cycle
  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd |=> m_wr);

  // R4: written byte is the one fetched in the previous cycle
  a_r4_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr |-> (m_wdata == $past(m_rdata)));

  // R3: a copy only begins after a length-low write
  a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && (reg_sel == 8'h2C)));

  // R3: no bus traffic while idle
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(m_rd || m_wr));

  // R6: the bank only moves after a byte write or a register write
  a_r6_bank_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(m_wr || reg_we));

endmodule

bind dma_bank_copy dma_bank_copy_chk #(.BANK_W(BANK_W), .DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .reg_we (reg_we),
  .reg_sel(reg_sel),
  .busy   (busy),
  .m_rd   (m_rd),
  .m_wr   (m_wr),
  .m_wdata(m_wdata),
  .m_rdata(m_rdata),
  .bank_q (bank_q)
);

// File: tb/test_dma_bank_copy.sv
`timescale 1ns/1ps
module test_dma_bank_copy;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        busy;
  logic        m_rd;
  logic        m_wr;
  logic [15:0] m_addr;
  logic        m_ext_sel;
  logic [25:0] m_ext_addr;
  logic [7:0]  m_wdata;
  logic [7:0]  m_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [7:0] pat_main(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] pat_ext(input logic [25:0] e);
    return e[7:0] ^ e[22:15] ^ 8'hC3;
  endfunction

  assign m_rdata = m_ext_sel ? pat_ext(m_ext_addr) : pat_main(m_addr);

  dma_bank_copy i_dma_bank_copy (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .m_rd      (m_rd),
    .m_wr      (m_wr),
    .m_addr    (m_addr),
    .m_ext_sel (m_ext_sel),
    .m_ext_addr(m_ext_addr),
    .m_wdata   (m_wdata),
    .m_rdata   (m_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // bus log sampled on the falling edge
  logic [15:0] w_addr [0:1023];
  logic [7:0]  w_data [0:1023];
  logic [15:0] r_addr [0:1023];
  logic        r_ext  [0:1023];
  logic [25:0] r_eaddr[0:1023];
  int nw = 0;
  int nr = 0;

  always @(negedge clk) begin
    if (m_wr && nw < 1024) begin
      w_addr[nw] = m_addr;
      w_data[nw] = m_wdata;
      nw++;
    end
    if (m_rd && nr < 1024) begin
      r_addr[nr]  = m_addr;
      r_ext[nr]   = m_ext_sel;
      r_eaddr[nr] = m_ext_addr;
      nr++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] sel, input logic [7:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] sel, output logic [7:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic read16(input logic [7:0] lo, output logic [15:0] v);
    logic [7:0] a, b;
    reg_read(lo, a);
    reg_read(lo + 8'd1, b);
    v = {b, a};
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d,
                       input logic [10:0] b, input logic [7:0] hi);
    reg_write(8'h28, s[7:0]);  reg_write(8'h29, s[15:8]);
    reg_write(8'h2A, d[7:0]);  reg_write(8'h2B, d[15:8]);
    reg_write(8'h36, b[7:0]);  reg_write(8'h37, {5'b0, b[10:8]});
    reg_write(8'h2D, hi);
    nw = 0; nr = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check(busy == 1'b0, "R1 busy", {31'b0, busy}, 0);
    check(!m_rd && !m_wr, "R1 bus idle", {30'b0, m_rd, m_wr}, 0);
    foreach (sels_r1[i]) begin
      reg_read(sels_r1[i], v);
      check(v == 8'h00, "R1 reg reset", {24'b0, v}, 0);
    end
  endtask
  logic [7:0] sels_r1 [8] = '{8'h28, 8'h29, 8'h2A, 8'h2B, 8'h2C, 8'h2D, 8'h36, 8'h37};

  task automatic t_regmap;
    logic [7:0] v;
    reg_write(8'h28, 8'h34); reg_write(8'h29, 8'h12);
    reg_write(8'h2A, 8'hCD); reg_write(8'h2B, 8'hAB);
    reg_write(8'h36, 8'h9E); reg_write(8'h37, 8'hFF);
    reg_write(8'h2D, 8'h1F);
    reg_read(8'h28, v); check(v == 8'h34, "R2 src lo", v, 8'h34);
    reg_read(8'h29, v); check(v == 8'h12, "R2 src hi", v, 8'h12);
    reg_read(8'h2A, v); check(v == 8'hCD, "R2 dst lo", v, 8'hCD);
    reg_read(8'h2B, v); check(v == 8'hAB, "R2 dst hi", v, 8'hAB);
    reg_read(8'h36, v); check(v == 8'h9E, "R2 bank lo", v, 8'h9E);
    reg_read(8'h37, v); check(v == 8'h07, "R2 bank hi", v, 8'h07);
    reg_read(8'h2D, v); check(v == 8'h00, "R2 len hi reads zero", v, 0);
    check(busy == 1'b0, "R2 no start from 0x2D", {31'b0, busy}, 0);
  endtask

  task automatic t_basic;
    int cyc;
    logic [15:0] v;
    setup(16'h1000, 16'h2000, 11'h0, 8'h00);
    reg_write(8'h2C, 8'h03);
    wait_idle(cyc);
    check(cyc == 8, "R3 busy cycles", cyc, 8);
    check(nw == 4, "R3 byte count", nw, 4);
    for (int i = 0; i < 4; i++) begin
      check(r_addr[i] == 16'h1000 + i, "R4 read addr", r_addr[i], 16'h1000 + i);
      check(r_ext[i] == 1'b0, "R5 low source not banked", r_ext[i], 0);
      check(w_addr[i] == 16'h2000 + i, "R7 dst increments", w_addr[i], 16'h2000 + i);
      check(w_data[i] == pat_main(16'h1000 + i), "R4 write data", w_data[i],
            pat_main(16'h1000 + i));
    end
    read16(8'h28, v); check(v == 16'h1004, "R9 src after", v, 16'h1004);
    read16(8'h2A, v); check(v == 16'h2004, "R9 dst after", v, 16'h2004);
  endtask

  task automatic t_bank_wrap;
    int cyc;
    logic [15:0] v;
    logic [7:0]  b;
    logic [25:0] e [4] = '{{11'h7FF, 15'h7FFE}, {11'h7FF, 15'h7FFF},
                           {11'h000, 15'h0000}, {11'h000, 15'h0001}};
    setup(16'hFFFE, 16'h0400, 11'h7FF, 8'h00);
    reg_write(8'h2C, 8'h03);
    wait_idle(cyc);
    check(nw == 4, "R6 byte count", nw, 4);
    for (int i = 0; i < 4; i++) begin
      check(r_ext[i] == 1'b1, "R5 banked select", r_ext[i], 1);
      check(r_eaddr[i] == e[i], "R6 banked address", r_eaddr[i], e[i]);
      check(w_data[i] == pat_ext(e[i]), "R5 banked data", w_data[i], pat_ext(e[i]));
    end
    read16(8'h28, v); check(v == 16'h8002, "R6 src reload", v, 16'h8002);
    reg_read(8'h36, b); check(b == 8'h00, "R6 bank lo wrap", b, 0);
    reg_read(8'h37, b); check(b == 8'h00, "R6 bank hi wrap", b, 0);
  endtask

  task automatic t_hold;
    int cyc;
    logic [15:0] v;
    setup(16'h0200, 16'h3F00, 11'h0, 8'h10);
    reg_write(8'h2C, 8'h02);
    wait_idle(cyc);
    check(nw == 3, "R7 hold count", nw, 3);
    for (int i = 0; i < 3; i++)
      check(w_addr[i] == 16'h3F00, "R7 hold address", w_addr[i], 16'h3F00);
    read16(8'h2A, v); check(v == 16'h3F00, "R7 dst unchanged", v, 16'h3F00);
    read16(8'h28, v); check(v == 16'h0203, "R9 src after hold", v, 16'h0203);
  endtask

  task automatic t_dst_wrap;
    int cyc;
    logic [15:0] v;
    logic [7:0]  b;
    setup(16'h0100, 16'hFFFF, 11'h005, 8'h00);
    reg_write(8'h2C, 8'h01);
    wait_idle(cyc);
    check(w_addr[0] == 16'hFFFF, "R8 first dst", w_addr[0], 16'hFFFF);
    check(w_addr[1] == 16'h0000, "R8 wrapped dst", w_addr[1], 16'h0000);
    read16(8'h2A, v); check(v == 16'h0001, "R8 dst after", v, 16'h0001);
    reg_read(8'h36, b); check(b == 8'h05, "R8 bank unchanged", b, 8'h05);
  endtask

  task automatic t_busy_ignore;
    int cyc;
    logic [15:0] v;
    setup(16'h0300, 16'h0400, 11'h0, 8'h00);
    reg_write(8'h2C, 8'd20);
    repeat (3) @(negedge clk);
    reg_write(8'h28, 8'hAA);
    reg_write(8'h2C, 8'h00);
    wait_idle(cyc);
    check(nw == 21, "R10 length not changed", nw, 21);
    read16(8'h28, v); check(v == 16'h0315, "R10 src write ignored", v, 16'h0315);
    read16(8'h2A, v); check(v == 16'h0415, "R10 dst after", v, 16'h0415);
  endtask

  task automatic t_long;
    int cyc;
    setup(16'h4000, 16'h5000, 11'h0, 8'h01);
    reg_write(8'h2C, 8'h00);
    wait_idle(cyc);
    check(nw == 257, "R3 high nibble length", nw, 257);
    check(cyc == 514, "R3 long busy cycles", cyc, 514);
    check(w_data[256] == pat_main(16'h4100), "R4 last byte", w_data[256],
          pat_main(16'h4100));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 8'h00; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_basic;
    t_bank_wrap;
    t_hold;
    t_dst_wrap;
    t_busy_ignore;
    t_long;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule